// File: doc/BRIEF.md
# Active Priority Tracker with Binary Point

This block follows the nesting of interrupt handlers on one processor. When an interrupt is acknowledged, the block derives the interrupt's group priority through a binary point. It then records the resulting preemption level in an active-priority bank. There is one bank for each interrupt group. The running priority becomes the group priority.

On end-of-interrupt, the block retires the most urgent active level of the named group. It then rebuilds the running priority from the most urgent level still active in either bank. Selecting an interrupt and clearing its pending state are handled elsewhere. The caller only presents a priority and a group with each strobe.

There are two binary points. The main one is used by group 0. The aliased one is used by group 1 unless the common-binary-point control is set. Each binary point has a floor that the parameter `MIN_BPR` fixes. The same parameter fixes how many preemption levels exist: 2^(8-(MIN_BPR+1)).

Top module: `apt_tracker`

## Requirements
- R1: After reset the running priority is 0x100 (idle), the main binary point is MIN_BPR and the aliased binary point is MIN_BPR+1.
- R2: `ack_grant_o` is high exactly when `ack_i` is high, `eoi_i` is low and `ack_prio_i` is strictly below the running priority. A refused acknowledge leaves the running priority unchanged.
- R3: On a granted acknowledge, the running priority becomes the group priority on the next cycle. The group priority is `ack_prio_i` ANDed with all-ones shifted left by (binary point + 1). A binary point of 7 gives 0.
- R4: A group-1 acknowledge (`ack_grp_i`=1) uses the aliased binary point while `cbpr_i` is low. With `cbpr_i` high, and for every group-0 acknowledge, the main binary point is used.
- R5: A binary point write (`bp_sel_i`=0 main, 1 aliased) stores the value. If the value is below the floor (MIN_BPR for main, MIN_BPR+1 for aliased), the floor is stored instead.
- R6: On end-of-interrupt, the lowest set level in the named group's bank is cleared. The running priority becomes (lowest level set in either bank) << (MIN_BPR+1), or 0x100 when no level is set.
- R7: An end-of-interrupt while the running priority is 0x100 has no effect.
- R8: An end-of-interrupt for a group whose bank is empty leaves the other bank and the running priority unchanged.
- R9: When `ack_i` and `eoi_i` are high in the same cycle, the end-of-interrupt is applied and the acknowledge is refused.
- R10: The banks are separate: retiring group 0 never clears a level that was recorded for group 1, even when that level is more urgent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_i | input | 1 | Acknowledge strobe |
| ack_prio_i | input | PRIO_W | Priority of the interrupt being acknowledged |
| ack_grp_i | input | 1 | Group of the acknowledged interrupt |
| cbpr_i | input | 1 | Common binary point: group 1 uses the main binary point |
| ack_grant_o | output | 1 | Acknowledge accepted in this cycle |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_grp_i | input | 1 | Group being retired |
| bp_we_i | input | 1 | Binary point write strobe |
| bp_sel_i | input | 1 | 0 selects main, 1 selects aliased binary point |
| bp_wdata_i | input | 3 | Binary point write value |
| run_prio_o | output | PRIO_W+1 | Running priority; 0x100 when idle |

## Verification
The bench nests acknowledges of both groups with three binary point choices: main, aliased, and aliased overridden by the common control. Each acknowledged priority has low bits that the mask must strip, so a wrong binary point choice gives a visibly different running priority. End-of-interrupt sequences are run in an order that exposes shared or mixed-up banks: group 0 is retired under a more urgent group-1 level, and an empty group is retired. A tie against the running priority, a zero priority, an end-of-interrupt while idle, and a simultaneous strobe pair separate a strict compare from a loose one, and show which strobe wins. Writes below the floor and a maximum binary point of 7 cover the clamp and the masking limits.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int unsigned BP_W = 3;

  function automatic logic [BP_W-1:0] bp_floor(input logic [BP_W-1:0] v,
                                               input logic [BP_W-1:0] lo);
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/apt_binpt.sv
module apt_binpt
  import apt_pkg::*;
#(
  parameter int unsigned MIN_BPR = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            sel_i,
  input  logic [BP_W-1:0] wdata_i,
  output logic [BP_W-1:0] bpr_o,
  output logic [BP_W-1:0] abpr_o
);
  localparam logic [BP_W-1:0] MinMain  = BP_W'(MIN_BPR);
  localparam logic [BP_W-1:0] MinAlias = BP_W'(MIN_BPR + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bpr_o  <= MinMain;
      abpr_o <= MinAlias;
    end else if (we_i) begin
      if (sel_i) abpr_o <= bp_floor(wdata_i, MinAlias);
      else       bpr_o  <= bp_floor(wdata_i, MinMain);
    end
  end
endmodule

// File: rtl/apt_gprio.sv
module apt_gprio
  import apt_pkg::*;
#(
  parameter int unsigned PRIO_W     = 8,
  parameter int unsigned MIN_BPR    = 2,
  parameter bit          HAS_GROUPS = 1'b1,
  localparam int unsigned SH        = MIN_BPR + 1,
  localparam int unsigned LVL_W     = PRIO_W - SH
) (
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              grp_i,
  input  logic              cbpr_i,
  input  logic [BP_W-1:0]   bpr_i,
  input  logic [BP_W-1:0]   abpr_i,
  output logic [PRIO_W-1:0] gprio_o,
  output logic [LVL_W-1:0]  lvl_o
);
  logic [BP_W-1:0]   bp;
  logic [BP_W:0]     shamt;
  logic [PRIO_W-1:0] mask;

  always_comb begin
    bp      = (HAS_GROUPS && grp_i && !cbpr_i) ? abpr_i : bpr_i;
    shamt   = {1'b0, bp} + 1'b1;
    mask    = {PRIO_W{1'b1}} << shamt;
    gprio_o = prio_i & mask;
    lvl_o   = gprio_o[PRIO_W-1:SH];
  end
endmodule

// File: rtl/apt_bank.sv
module apt_bank #(
  parameter int unsigned LEVELS = 32,
  parameter int unsigned LVL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [LVL_W-1:0]  set_lvl_i,
  input  logic              drop_i,
  output logic [LEVELS-1:0] bank_o,
  output logic [LEVELS-1:0] bank_nxt_o
);
  always_comb begin
    bank_nxt_o = bank_o;
    // lowest set bit = most urgent level, same as first nonzero word's lsb
    if (drop_i) bank_nxt_o = bank_nxt_o & (bank_nxt_o - 1'b1);
    if (set_i)  bank_nxt_o[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_o <= '0;
    else         bank_o <= bank_nxt_o;
  end
endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
  import apt_pkg::*;
#(
  parameter int unsigned PRIO_W     = 8,
  parameter int unsigned MIN_BPR    = 2,
  parameter bit          HAS_GROUPS = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_i,
  input  logic [PRIO_W-1:0] ack_prio_i,
  input  logic              ack_grp_i,
  input  logic              cbpr_i,
  output logic              ack_grant_o,
  input  logic              eoi_i,
  input  logic              eoi_grp_i,
  input  logic              bp_we_i,
  input  logic              bp_sel_i,
  input  logic [BP_W-1:0]   bp_wdata_i,
  output logic [PRIO_W:0]   run_prio_o
);
  localparam int unsigned SH     = MIN_BPR + 1;
  localparam int unsigned LVL_W  = PRIO_W - SH;
  localparam int unsigned LEVELS = 1 << LVL_W;
  localparam int unsigned NBANK  = HAS_GROUPS ? 2 : 1;
  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  logic [BP_W-1:0]   bpr, abpr;
  logic [PRIO_W-1:0] gprio;
  logic [LVL_W-1:0]  ack_lvl;
  logic              ack_g, eoi_g, eoi_eff;
  logic [LEVELS-1:0] bank     [2];
  logic [LEVELS-1:0] bank_nxt [2];
  logic [LEVELS-1:0] act_any;
  logic              act_found;
  logic [LVL_W-1:0]  act_lvl;
  logic [PRIO_W:0]   run_q, run_d, run_calc;

  assign ack_g       = HAS_GROUPS ? ack_grp_i : 1'b0;
  assign eoi_g       = HAS_GROUPS ? eoi_grp_i : 1'b0;
  assign ack_grant_o = ack_i && !eoi_i && ({1'b0, ack_prio_i} < run_q);
  assign eoi_eff     = eoi_i && (run_q != IDLE);

  apt_binpt #(.MIN_BPR(MIN_BPR)) i_binpt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bp_we_i),
    .sel_i  (bp_sel_i),
    .wdata_i(bp_wdata_i),
    .bpr_o  (bpr),
    .abpr_o (abpr)
  );

  apt_gprio #(.PRIO_W(PRIO_W), .MIN_BPR(MIN_BPR), .HAS_GROUPS(HAS_GROUPS)) i_gprio (
    .prio_i (ack_prio_i),
    .grp_i  (ack_g),
    .cbpr_i (cbpr_i),
    .bpr_i  (bpr),
    .abpr_i (abpr),
    .gprio_o(gprio),
    .lvl_o  (ack_lvl)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    if (g < NBANK) begin : g_on
      apt_bank #(.LEVELS(LEVELS), .LVL_W(LVL_W)) i_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (ack_grant_o && (ack_g == 1'(g))),
        .set_lvl_i (ack_lvl),
        .drop_i    (eoi_eff && (eoi_g == 1'(g))),
        .bank_o    (bank[g]),
        .bank_nxt_o(bank_nxt[g])
      );
    end else begin : g_off
      assign bank[g]     = '0;
      assign bank_nxt[g] = '0;
    end
  end

  assign act_any = bank_nxt[0] | bank_nxt[1];

  always_comb begin
    act_found = 1'b0;
    act_lvl   = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (act_any[i]) begin
        act_found = 1'b1;
        act_lvl   = LVL_W'(i);
      end
    end
    run_calc = act_found ? {1'b0, act_lvl, {SH{1'b0}}} : IDLE;
  end

  always_comb begin
    run_d = run_q;
    if (ack_grant_o)  run_d = {1'b0, gprio};
    else if (eoi_eff) run_d = run_calc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= IDLE;
    else         run_q <= run_d;
  end

  assign run_prio_o = run_q;
endmodule

// File: rtl/apt_tracker_chk.sv
module apt_tracker_chk #(
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned MIN_BPR = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic [PRIO_W-1:0] ack_prio_i,
  input logic              ack_grant_o,
  input logic              eoi_i,
  input logic [PRIO_W:0]   run_prio_o
);
  localparam int unsigned SH = MIN_BPR + 1;
  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  a_r2_refused_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_grant_o && !eoi_i) |=> $stable(run_prio_o));

  a_r3_grant_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_grant_o |=> (run_prio_o < $past(run_prio_o)) &&
                    (run_prio_o <= {1'b0, $past(ack_prio_i)}));

  a_r3_level_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_prio_o[SH-1:0] == '0) && (run_prio_o <= IDLE));

  a_r6_drop_not_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i) |=> run_prio_o >= $past(run_prio_o));

  a_r7_idle_eoi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && run_prio_o == IDLE) |=> run_prio_o == IDLE);

  a_r9_eoi_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && eoi_i) |-> !ack_grant_o);
endmodule

bind apt_tracker apt_tracker_chk #(.PRIO_W(PRIO_W), .MIN_BPR(MIN_BPR)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .ack_prio_i (ack_prio_i),
  .ack_grant_o(ack_grant_o),
  .eoi_i      (eoi_i),
  .run_prio_o (run_prio_o)
);

// File: tb/test_apt_tracker.sv
module test_apt_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack = 1'b0, ack_grp = 1'b0, cbpr = 1'b0, eoi = 1'b0, eoi_grp = 1'b0;
  logic [7:0] ack_prio = '0;
  logic       bp_we = 1'b0, bp_sel = 1'b0;
  logic [2:0] bp_wdata = '0;
  logic       grant;
  logic [8:0] run;

  int n_run = 0, n_fail = 0;

  typedef struct { logic [8:0] exp; string tag; } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  apt_tracker i_apt_tracker (
    .clk_i(clk), .rst_ni(rst_n), .ack_i(ack), .ack_prio_i(ack_prio),
    .ack_grp_i(ack_grp), .cbpr_i(cbpr), .ack_grant_o(grant), .eoi_i(eoi),
    .eoi_grp_i(eoi_grp), .bp_we_i(bp_we), .bp_sel_i(bp_sel),
    .bp_wdata_i(bp_wdata), .run_prio_o(run)
  );

  // monitor: compare running priority after each edge that consumed an op
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      n_run++;
      if (run !== it.exp) begin
        n_fail++;
        $display("FAIL %s run_prio act=%h exp=%h", it.tag, run, it.exp);
      end
    end
  end

  task automatic op(input logic a, input logic [7:0] p, input logic g, input logic cb,
                    input logic e, input logic eg, input logic exp_grant,
                    input logic [8:0] exp_run, input string tag);
    @(negedge clk);
    ack = a; ack_prio = p; ack_grp = g; cbpr = cb; eoi = e; eoi_grp = eg;
    #1;
    if (a) begin
      n_run++;
      if (grant !== exp_grant) begin
        n_fail++;
        $display("FAIL %s grant act=%b exp=%b", tag, grant, exp_grant);
      end
    end
    exp_q.push_back('{exp_run, tag});
    @(posedge clk); #1;
    ack = 1'b0; eoi = 1'b0;
  endtask

  task automatic bp_write(input logic sel, input logic [2:0] v);
    @(negedge clk);
    bp_we = 1'b1; bp_sel = sel; bp_wdata = v;
    @(posedge clk); #1;
    bp_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    n_run++;
    if (run !== 9'h100) begin
      n_fail++;
      $display("FAIL R1 reset run_prio act=%h exp=100", run);
    end
    // ack a p g cb e eg grant exp
    op(0, 8'h00, 0, 0, 1, 0, 0, 9'h100, "R7 eoi idle");
    op(1, 8'h65, 0, 0, 0, 0, 1, 9'h060, "R3 grp0 main bp");
    op(1, 8'h60, 0, 0, 0, 0, 0, 9'h060, "R2 tie refused");
    op(1, 8'h5F, 1, 0, 0, 0, 1, 9'h050, "R4 grp1 aliased bp");
    op(1, 8'h4F, 1, 1, 0, 0, 1, 9'h048, "R4 grp1 common bp");
    op(0, 8'h00, 0, 0, 1, 0, 0, 9'h048, "R10 grp0 drop keeps grp1");
    op(0, 8'h00, 0, 0, 1, 0, 0, 9'h048, "R8 empty bank eoi");
    op(0, 8'h00, 0, 0, 1, 1, 0, 9'h050, "R6 grp1 drop");
    op(1, 8'h10, 0, 0, 1, 1, 0, 9'h100, "R9 simultaneous");
    bp_write(0, 3'd1);
    op(1, 8'h27, 0, 0, 0, 0, 1, 9'h020, "R5 main clamp");
    bp_write(1, 3'd5);
    op(1, 8'h1F, 1, 0, 0, 0, 1, 9'h000, "R5 aliased write");
    op(1, 8'h00, 0, 0, 0, 0, 0, 9'h000, "R2 zero refused");
    op(0, 8'h00, 0, 0, 1, 1, 0, 9'h020, "R6 reveal grp0");
    op(0, 8'h00, 0, 0, 1, 0, 0, 9'h100, "R6 back to idle");
    bp_write(1, 3'd0);
    op(1, 8'h1F, 1, 0, 0, 0, 1, 9'h010, "R5 aliased clamp");
    op(0, 8'h00, 0, 0, 1, 1, 0, 9'h100, "R6 idle again");
    bp_write(0, 3'd7);
    op(1, 8'hFE, 0, 0, 0, 0, 1, 9'h000, "R3 bp seven");
    op(0, 8'h00, 0, 0, 1, 0, 0, 9'h100, "R6 final drop");
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule